// File: doc/BRIEF.md
# Programmable interval timer channel

This block is a single counter channel of an interval timer. A host writes a 16-bit reload value together with a mode number. From then on the channel counts input ticks, which arrive as a one-cycle enable at about 1.193 MHz, derived elsewhere from the system clock. It drives one output whose waveform depends on the mode. Six waveforms come out of the same counter: a level that rises at terminal count, a one-shot window, a one-tick rate pulse, a square wave, and a single strobe started either by software or by the gate.

A gate input freezes counting in the free-running modes and retriggers the count in the gate-triggered modes. The count still to go can be read as two bytes. It can be read live, or frozen by a latch command so that both bytes come from the same instant. Counting is binary only. A reload of zero stands for 65536.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the channel is in mode 3 with a count of 65536 and zero elapsed ticks, so `wave_out` is 1 and `rd_data` reads 0x00.
- R2: A cycle with `cfg_wr` high loads `cfg_mode` and `cfg_count` and restarts the elapsed tick count at zero. A `cfg_count` of 0 means 65536. Mode codes 6 and 7 act as 2 and 3.
- R3: Mode 0: `wave_out` is 1 once the elapsed count e has reached the count N, and stays 1 until the next load.
- R4: Mode 1: `wave_out` is 1 while e < N and 0 afterwards.
- R5: Mode 2: `wave_out` is 1 exactly when e is a nonzero multiple of N.
- R6: Mode 3: `wave_out` is 1 while (e mod N) < floor(N/2), and 0 for the rest of each period.
- R7: Modes 4 and 5: `wave_out` is 1 only while e equals N.
- R8: e advances by one at a clock edge only when `tick_en` is high in that cycle.
- R9: With `gate` low, e holds in modes 0, 2, 3 and 4. In modes 1 and 5, ticks count whatever the gate level, and a rising edge on `gate` resets e to zero.
- R10: The readable count is N - (e mod N) in modes 2 and 3, and max(N - e, 0) in the other modes, taken modulo 65536. `rd_data` shows its low byte when the byte pointer is 0 and its high byte when it is 1. Each `rd_strobe` toggles the pointer.
- R11: `latch_cmd` copies the readable count into a hold register and points the byte pointer at the low byte. Reads return the held value until its high byte has been read. A latch while a value is held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count tick |
| gate | input | 1 | Gate level |
| cfg_wr | input | 1 | Load mode and count |
| cfg_mode | input | 3 | Mode code 0 to 7 |
| cfg_count | input | 16 | Reload value, 0 means 65536 |
| latch_cmd | input | 1 | Freeze the readable count |
| rd_strobe | input | 1 | Consume one byte of the readback |
| rd_data | output | 8 | Selected byte of the held or live count |
| wave_out | output | 1 | Mode-dependent output waveform |

## Verification
Each mode is run with small counts so that several periods or the whole one-shot window fit in a short run. Odd and even counts in mode 3 separate a correct half-period split from an off-by-one. Gate-low stretches in the free-running modes show that counting freezes, not restarts. Gate rising edges in modes 1 and 5 show that the count restarts there. Cycles without a tick show that the clock alone does not advance the count. A latch followed by further ticks, a second latch and both byte reads tells the snapshot apart from the live count. A zero reload with a readback of 0xFFF6 after ten ticks confirms the 65536 reading.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int CNT_W  = 16;
  localparam int FULL_W = CNT_W + 1;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmode_e;

  // Codes 6 and 7 fold onto the rate and square modes.
  function automatic tmode_e norm_mode(input logic [2:0] code);
    case (code)
      3'd0: norm_mode = M_TERM;
      3'd1: norm_mode = M_ONESHOT;
      3'd2: norm_mode = M_RATE;
      3'd4: norm_mode = M_SWSTB;
      3'd5: norm_mode = M_HWSTB;
      3'd6: norm_mode = M_RATE;
      default: norm_mode = M_SQUARE;
    endcase
  endfunction

  function automatic logic [FULL_W-1:0] full_count(input logic [CNT_W-1:0] v);
    full_count = (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
  endfunction

  function automatic logic is_periodic(input tmode_e m);
    is_periodic = (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic is_gate_trig(input tmode_e m);
    is_gate_trig = (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction

  function automatic logic wave_level(input tmode_e m, input logic [FULL_W-1:0] pos,
                                      input logic [FULL_W-1:0] full, input logic wrapped);
    case (m)
      M_TERM:    wave_level = (pos >= full);
      M_ONESHOT: wave_level = (pos < full);
      M_RATE:    wave_level = wrapped && (pos == '0);
      M_SQUARE:  wave_level = (pos < (full >> 1));
      default:   wave_level = (pos == full);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] remaining(input tmode_e m, input logic [FULL_W-1:0] pos,
                                                 input logic [FULL_W-1:0] full);
    logic [FULL_W-1:0] diff;
    if (!is_periodic(m) && (pos > full)) diff = '0;
    else diff = full - pos;
    remaining = diff[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
  import timer_pkg::*;
#(
  parameter int PW = FULL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ev,
  input  logic          restart_ev,
  input  logic          tick_run,
  input  logic          periodic,
  input  logic [PW-1:0] full,
  output logic [PW-1:0] pos,
  output logic          wrapped,
  output logic          wrap_ev
);
  localparam logic [PW-1:0] ONE = PW'(1);

  assign wrap_ev = tick_run && periodic && (pos == full - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      wrapped <= 1'b0;
    end else if (load_ev || restart_ev) begin
      pos     <= '0;
      wrapped <= 1'b0;
    end else if (tick_run) begin
      if (wrap_ev) begin
        pos     <= '0;
        wrapped <= 1'b1;
      end else if (periodic || (pos <= full)) begin
        pos <= pos + ONE;
      end
    end
  end
endmodule

// File: rtl/tmr_wave_gen.sv
`timescale 1ns/1ps
module tmr_wave_gen
  import timer_pkg::*;
(
  input  tmode_e            mode,
  input  logic [FULL_W-1:0] pos,
  input  logic [FULL_W-1:0] full,
  input  logic              wrapped,
  output logic              level,
  output logic [CNT_W-1:0]  live_val
);
  always_comb begin
    level    = wave_level(mode, pos, full, wrapped);
    live_val = remaining(mode, pos, full);
  end
endmodule

// File: rtl/tmr_readback.sv
`timescale 1ns/1ps
module tmr_readback #(
  parameter int VW = 16,
  localparam int BW = VW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_cmd,
  input  logic          rd_strobe,
  input  logic [VW-1:0] live_val,
  output logic [BW-1:0] rd_data,
  output logic          hold_active,
  output logic [VW-1:0] hold_val
);
  logic          hi_sel;
  logic [VW-1:0] src;

  assign src     = hold_active ? hold_val : live_val;
  assign rd_data = hi_sel ? src[VW-1:BW] : src[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_active <= 1'b0;
      hold_val    <= '0;
      hi_sel      <= 1'b0;
    end else if (latch_cmd && !hold_active) begin
      hold_active <= 1'b1;
      hold_val    <= live_val;
      hi_sel      <= 1'b0;
    end else if (rd_strobe) begin
      hi_sel <= ~hi_sel;
      if (hold_active && hi_sel) hold_active <= 1'b0;
    end
  end
endmodule

// File: rtl/interval_timer_chan.sv
`timescale 1ns/1ps
module interval_timer_chan
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             latch_cmd,
  input  logic             rd_strobe,
  output logic [7:0]       rd_data,
  output logic             wave_out
);
  tmode_e            mode_q;
  logic [FULL_W-1:0] full_q;
  logic              gate_q;
  logic [FULL_W-1:0] pos;
  logic              wrapped;
  logic              wrap_ev;
  logic [CNT_W-1:0]  live_val;
  logic              hold_active;
  logic [CNT_W-1:0]  hold_val;

  // Named events for the checker.
  logic load_ev, restart_ev, tick_run, gate_rise;
  assign load_ev    = cfg_wr;
  assign gate_rise  = gate && !gate_q;
  assign restart_ev = !cfg_wr && is_gate_trig(mode_q) && gate_rise;
  assign tick_run   = tick_en && !cfg_wr && !restart_ev && (gate || is_gate_trig(mode_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_SQUARE;
      full_q <= full_count('0);
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (cfg_wr) begin
        mode_q <= norm_mode(cfg_mode);
        full_q <= full_count(cfg_count);
      end
    end
  end

  tmr_count_core #(.PW(FULL_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .restart_ev(restart_ev),
    .tick_run(tick_run), .periodic(is_periodic(mode_q)), .full(full_q),
    .pos(pos), .wrapped(wrapped), .wrap_ev(wrap_ev)
  );

  tmr_wave_gen u_wave (
    .mode(mode_q), .pos(pos), .full(full_q), .wrapped(wrapped),
    .level(wave_out), .live_val(live_val)
  );

  tmr_readback #(.VW(CNT_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .latch_cmd(latch_cmd), .rd_strobe(rd_strobe),
    .live_val(live_val), .rd_data(rd_data), .hold_active(hold_active),
    .hold_val(hold_val)
  );
endmodule

// File: rtl/tmr_chan_chk.sv
`timescale 1ns/1ps
module tmr_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        gate,
  input logic        cfg_wr,
  input logic        rd_strobe,
  input logic        wave_out,
  input logic [2:0]  mode,
  input logic [16:0] pos,
  input logic        restart_ev,
  input logic        tick_run,
  input logic        hold_active,
  input logic [15:0] hold_val
);
  // R2
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (pos == 17'd0));
  // R3
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && wave_out && !cfg_wr) |=> wave_out);
  // R4
  oneshot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !wave_out && !cfg_wr && !restart_ev) |=> !wave_out);
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd4 || mode == 3'd5) && wave_out && tick_run) |=> !wave_out);
  // R8
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cfg_wr && !restart_ev) |=> $stable(pos));
  // R9
  gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !cfg_wr && mode != 3'd1 && mode != 3'd5) |=> $stable(pos));
  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && !rd_strobe) |=> (hold_active && $stable(hold_val)));
endmodule

bind interval_timer_chan tmr_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate), .cfg_wr(cfg_wr),
  .rd_strobe(rd_strobe), .wave_out(wave_out), .mode(mode_q), .pos(pos),
  .restart_ev(restart_ev), .tick_run(tick_run), .hold_active(hold_active),
  .hold_val(hold_val)
);

// File: tb/interval_timer_chan_test.sv
`timescale 1ns/1ps
module interval_timer_chan_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, gate = 1'b0, cfg_wr = 1'b0, latch_cmd = 1'b0, rd_strobe = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [15:0] cfg_count = 16'd0;
  logic [7:0] rd_data;
  logic wave_out;

  int checks = 0, failures = 0;
  bit done = 0;

  // Bench model of the channel, from the requirements.
  int m_mode = 3, m_n = 65536, m_d = 0;
  bit m_gprev = 0;

  always #4 clk = ~clk;

  interval_timer_chan uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate), .cfg_wr(cfg_wr),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .latch_cmd(latch_cmd),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .wave_out(wave_out)
  );

  function automatic bit exp_out();
    case (m_mode)
      0: return m_d >= m_n;
      1: return m_d < m_n;
      2: return (m_d % m_n == 0) && (m_d != 0);
      3: return (m_d % m_n) < (m_n / 2);
      default: return m_d == m_n;
    endcase
  endfunction

  function automatic string mode_tag();
    case (m_mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock cycle; inputs driven at the falling edge, outputs sampled at the next one.
  task automatic cyc(input bit tk, input bit g, input bit wr = 0, input int wm = 0,
                     input int wv = 0, input bit lt = 0, input bit rd = 0);
    bit rise, trig;
    tick_en = tk; gate = g; cfg_wr = wr; cfg_mode = 3'(wm); cfg_count = 16'(wv);
    latch_cmd = lt; rd_strobe = rd;
    rise = g && !m_gprev;
    trig = (m_mode == 1) || (m_mode == 5);
    if (wr) begin
      m_mode = (wm == 6) ? 2 : (wm == 7) ? 3 : wm;
      m_n = (wv == 0) ? 65536 : wv;
      m_d = 0;
    end else if (trig && rise) m_d = 0;
    else if (tk && (g || trig)) m_d++;
    m_gprev = g;
    @(posedge clk);
    @(negedge clk);
    tick_en = 0; cfg_wr = 0; latch_cmd = 0; rd_strobe = 0;
    check({mode_tag(), " wave"}, wave_out, exp_out());
  endtask

  task automatic run(input int n, input bit tk, input bit g);
    for (int i = 0; i < n; i++) cyc(tk, g);
  endtask

  task automatic rd_byte(input string tag, input int exp, input bit g);
    check(tag, rd_data, exp);
    cyc(0, g, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    check("R1 wave", wave_out, 1);
    check("R1 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_mode0();
    cyc(0, 1, 1, 0, 5);
    check("R2 loaded e=0", wave_out, 0);
    run(3, 1, 1);
    run(3, 0, 1);   // R8 no ticks
    run(3, 1, 0);   // R9 frozen
    run(4, 1, 1);
    check("R3 high after count", wave_out, 1);
  endtask

  task automatic t_mode1();
    cyc(0, 0, 1, 1, 4);
    run(6, 1, 0);   // R9 counts with gate low
    check("R4 low after window", wave_out, 0);
    cyc(1, 1);      // R9 rising gate restarts
    check("R9 restart mode1", wave_out, 1);
    run(6, 1, 1);
  endtask

  task automatic t_mode2();
    cyc(0, 1, 1, 2, 3);
    run(10, 1, 1);
    cyc(0, 1, 1, 6, 3);   // R2 code 6 acts as 2
    run(7, 1, 1);
  endtask

  task automatic t_mode3();
    cyc(0, 1, 1, 3, 6);
    run(13, 1, 1);
    cyc(0, 1, 1, 7, 5);   // R2 code 7 acts as 3, odd count
    run(3, 1, 0);
    run(11, 1, 1);
  endtask

  task automatic t_strobes();
    cyc(0, 1, 1, 4, 3);
    run(2, 1, 1);
    run(2, 1, 0);
    run(4, 1, 1);
    cyc(0, 0, 1, 5, 3);
    run(5, 1, 0);
    cyc(0, 1);           // R9 restart in mode 5
    run(5, 1, 1);
  endtask

  task automatic t_latch();
    cyc(0, 1, 1, 2, 1000);
    run(7, 1, 1);
    cyc(0, 1, 0, 0, 0, 1);   // R11 latch 993
    run(5, 1, 1);
    rd_byte("R11 held low", 8'hE1, 1);
    cyc(0, 1, 0, 0, 0, 1);   // R11 ignored second latch
    rd_byte("R11 held high", 8'h03, 1);
    rd_byte("R10 live low", 8'hDC, 1);
    rd_byte("R10 live high", 8'h03, 1);
  endtask

  task automatic t_zero_count();
    cyc(0, 1, 1, 3, 0);
    run(10, 1, 1);
    check("R2 zero count wave", wave_out, 1);
    rd_byte("R10 65536 low", 8'hF6, 1);
    rd_byte("R10 65536 high", 8'hFF, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_strobes();
    t_latch();
    t_zero_count();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule